// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block sits in front of one processor and decides which single interrupt source is presented to it. It keeps five items of state: the processor's current priority threshold, the priority of a software-raised inter-processor request, the number of the source that is pending together with its priority, and a flag that records a delivery refused while the processor was busy. Priorities are inverted: a smaller number is more urgent, and 0xFF means "nothing".

A source controller offers interrupts on a valid/ready channel. The processor side issues accept reads, threshold writes, inter-processor priority writes and end-of-interrupt writes, each on its own strobe. Every request is folded into the state in the cycle it is seen. Results come out one clock later as single-cycle pulses: the verdict on each offer, up to three displaced source numbers to be offered again, a resend request that tells the source side to replay refused deliveries, an end-of-interrupt forward and the accept response word. The interrupt line to the processor is a function of the registered state.

The offer channel never applies back-pressure: `offer_ready` is held high, and an offer is consumed in any cycle where `offer_valid` is high. The response pulses have no ready input, so the consumer must take each of them in the cycle it appears.

Top module: `irq_presenter`

## Requirements
- R1: An offer is taken only when its priority is strictly smaller than the threshold, the inter-processor priority and the pending priority. `offer_done` pulses one cycle after every offer, and `offer_taken` pulses with it when the offer was taken.
- R2: A taken offer replaces the pending source and the pending priority and reports the source it displaced on reject slot 2. A refused offer sets the resend flag.
- R3: `irq_out` is high exactly when the pending source is nonzero and the pending priority is smaller than the threshold.
- R4: An accept returns, one cycle later on `xirr_data`, the threshold in bits 31:24 and the pending source in bits 23:0. When the pending source was nonzero, the threshold takes the pending priority, the pending priority becomes 0xFF and the pending source becomes 0.
- R5: On an inter-processor priority write, when the new value is below the threshold and at or below the pending priority, the pending source is displaced (reject slot 1) and source 2 becomes pending at the new value. When the value increased, a set resend flag is cleared and `resend_req` pulses.
- R6: A threshold write equal to the current threshold changes nothing. A smaller value loads the threshold. If the new value is at or below the pending priority, the pending source is displaced (reject slot 0), and the pending source and priority are cleared to 0 and 0xFF.
- R7: A larger threshold write loads it. Source 2 becomes pending at the inter-processor priority when that priority is below the new threshold and at or below the pending priority. A set resend flag is cleared and `resend_req` pulses.
- R8: An end-of-interrupt word holds a new threshold in bits 31:24 and a source in bits 23:0. It applies the R7 behaviour unconditionally, whatever the new value is, and never displaces a source. It forwards the source on `eoi_fwd_src` unless the source is 2.
- R9: A displaced source numbered 0 or 2 is never reported on any reject slot.
- R10: After reset the threshold is 0, the inter-processor priority and the pending priority are 0xFF, the pending source is 0 and the resend flag is clear.
- R11: Requests arriving in the same cycle are applied in this order: end-of-interrupt, threshold write, inter-processor write, offer, accept. Each stage sees the state left by the one before.
- R12: `offer_ready` is always high. Every response is a single-cycle pulse registered one clock after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source controller offers an interrupt |
| offer_ready | output | 1 | Always high; an offer is consumed when valid |
| offer_src | input | SRC_W | Offered source number |
| offer_prio | input | PRI_W | Offered priority |
| acc_valid | input | 1 | Accept request |
| cppr_wr_valid | input | 1 | Threshold write strobe |
| cppr_wr_data | input | PRI_W | New threshold |
| mfrr_wr_valid | input | 1 | Inter-processor priority write strobe |
| mfrr_wr_data | input | PRI_W | New inter-processor priority |
| eoi_valid | input | 1 | End-of-interrupt write strobe |
| eoi_word | input | PRI_W+SRC_W | New threshold (high byte) and finished source |
| offer_done | output | 1 | Verdict on last cycle's offer is valid |
| offer_taken | output | 1 | Last cycle's offer was taken |
| rej_valid | output | 3 | Per-slot displaced-source pulse (0 threshold, 1 inter-processor, 2 offer) |
| rej_src | output | 3*SRC_W | Displaced source numbers, slot k at bits k*SRC_W upward |
| resend_req | output | 1 | Source side must replay refused deliveries |
| eoi_fwd_valid | output | 1 | End-of-interrupt forwarded to the source side |
| eoi_fwd_src | output | SRC_W | Forwarded source number |
| xirr_valid | output | 1 | Accept response valid |
| xirr_data | output | PRI_W+SRC_W | Accept response word |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The bench resets the block and then sweeps thresholds, inter-processor priorities and pairs of offer priorities, including ties, to test the strict-inequality rule. A design that used "at or below" on offers would take an equal-priority offer and displace a source that should have stayed pending. Each sweep then runs an accept, an end-of-interrupt, a raise of the inter-processor priority and a lowered threshold written twice. A wrong resend latch shows up as a missing or duplicated `resend_req`. An equal-value write that is not ignored shows up as a second rejection. A missing filter shows up as source 2 appearing on a reject slot. A final pass drives all 32 combinations of simultaneous requests against a pending source. A design that served them in another order returns the wrong accept word or threshold.

// File: rtl/irq_pres_pkg.sv
package irq_pres_pkg;
  typedef enum int unsigned {
    STG_EOI    = 0,
    STG_CPPR   = 1,
    STG_MFRR   = 2,
    STG_OFFER  = 3,
    STG_ACCEPT = 4
  } stage_e;
  localparam int unsigned NUM_STAGES = 5;
  // stages that may displace a source: CPPR, MFRR, OFFER
  localparam int unsigned REJ_SLOTS = 3;
  localparam int unsigned REJ_BASE  = 1;
endpackage

// File: rtl/ipr_cppr_stage.sv
module ipr_cppr_stage #(
  parameter int unsigned PRI_W       = 8,
  parameter int unsigned SRC_W       = 24,
  parameter int unsigned IPI_SRC     = 2,
  parameter bit          ALWAYS_DOWN = 1'b0
) (
  input  logic             en_i,
  input  logic [PRI_W-1:0] new_cppr_i,
  input  logic [PRI_W-1:0] mfrr_i,
  input  logic [PRI_W-1:0] cppr_i,
  input  logic [PRI_W-1:0] pend_i,
  input  logic [SRC_W-1:0] xisr_i,
  input  logic             need_i,
  output logic [PRI_W-1:0] cppr_o,
  output logic [PRI_W-1:0] pend_o,
  output logic [SRC_W-1:0] xisr_o,
  output logic             need_o,
  output logic             rej_o,
  output logic [SRC_W-1:0] rej_src_o,
  output logic             resend_o
);
  localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_SRC);

  logic go_down, go_up;

  generate
    if (ALWAYS_DOWN) begin : g_eoi
      assign go_down = en_i;
      assign go_up   = 1'b0;
    end else begin : g_write
      assign go_down = en_i && (new_cppr_i > cppr_i);
      assign go_up   = en_i && (new_cppr_i < cppr_i);
    end
  endgenerate

  always_comb begin
    cppr_o    = cppr_i;
    pend_o    = pend_i;
    xisr_o    = xisr_i;
    need_o    = need_i;
    rej_o     = 1'b0;
    rej_src_o = '0;
    resend_o  = 1'b0;
    if (go_down) begin
      cppr_o = new_cppr_i;
      if ((mfrr_i < new_cppr_i) && (mfrr_i <= pend_i)) begin
        pend_o = mfrr_i;
        xisr_o = IPI_ID;
      end
      resend_o = need_i;
      need_o   = 1'b0;
    end else if (go_up) begin
      cppr_o = new_cppr_i;
      if (new_cppr_i <= pend_i) begin
        rej_o     = 1'b1;
        rej_src_o = xisr_i;
        xisr_o    = '0;
        pend_o    = '1;
      end
    end
  end
endmodule

// File: rtl/ipr_mfrr_stage.sv
module ipr_mfrr_stage #(
  parameter int unsigned PRI_W   = 8,
  parameter int unsigned SRC_W   = 24,
  parameter int unsigned IPI_SRC = 2
) (
  input  logic             en_i,
  input  logic [PRI_W-1:0] new_mfrr_i,
  input  logic [PRI_W-1:0] mfrr_i,
  input  logic [PRI_W-1:0] cppr_i,
  input  logic [PRI_W-1:0] pend_i,
  input  logic [SRC_W-1:0] xisr_i,
  input  logic             need_i,
  output logic [PRI_W-1:0] mfrr_o,
  output logic [PRI_W-1:0] pend_o,
  output logic [SRC_W-1:0] xisr_o,
  output logic             need_o,
  output logic             rej_o,
  output logic [SRC_W-1:0] rej_src_o,
  output logic             resend_o
);
  localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_SRC);

  always_comb begin
    mfrr_o    = mfrr_i;
    pend_o    = pend_i;
    xisr_o    = xisr_i;
    need_o    = need_i;
    rej_o     = 1'b0;
    rej_src_o = '0;
    resend_o  = 1'b0;
    if (en_i) begin
      mfrr_o = new_mfrr_i;
      if ((new_mfrr_i < cppr_i) && (new_mfrr_i <= pend_i)) begin
        rej_o     = 1'b1;
        rej_src_o = xisr_i;
        pend_o    = new_mfrr_i;
        xisr_o    = IPI_ID;
      end
      if (new_mfrr_i > mfrr_i) begin
        resend_o = need_i;
        need_o   = 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipr_offer_stage.sv
module ipr_offer_stage #(
  parameter int unsigned PRI_W = 8,
  parameter int unsigned SRC_W = 24
) (
  input  logic             en_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [PRI_W-1:0] prio_i,
  input  logic [PRI_W-1:0] mfrr_i,
  input  logic [PRI_W-1:0] cppr_i,
  input  logic [PRI_W-1:0] pend_i,
  input  logic [SRC_W-1:0] xisr_i,
  input  logic             need_i,
  output logic [PRI_W-1:0] pend_o,
  output logic [SRC_W-1:0] xisr_o,
  output logic             need_o,
  output logic             taken_o,
  output logic             rej_o,
  output logic [SRC_W-1:0] rej_src_o
);
  logic wins;
  assign wins = (prio_i < cppr_i) && (prio_i < mfrr_i) && (prio_i < pend_i);

  always_comb begin
    pend_o    = pend_i;
    xisr_o    = xisr_i;
    need_o    = need_i;
    taken_o   = 1'b0;
    rej_o     = 1'b0;
    rej_src_o = '0;
    if (en_i) begin
      if (wins) begin
        taken_o   = 1'b1;
        rej_o     = 1'b1;
        rej_src_o = xisr_i;
        xisr_o    = src_i;
        pend_o    = prio_i;
      end else begin
        need_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipr_accept_stage.sv
module ipr_accept_stage #(
  parameter int unsigned PRI_W = 8,
  parameter int unsigned SRC_W = 24
) (
  input  logic                   en_i,
  input  logic [PRI_W-1:0]       cppr_i,
  input  logic [PRI_W-1:0]       pend_i,
  input  logic [SRC_W-1:0]       xisr_i,
  output logic [PRI_W-1:0]       cppr_o,
  output logic [PRI_W-1:0]       pend_o,
  output logic [SRC_W-1:0]       xisr_o,
  output logic [PRI_W+SRC_W-1:0] word_o
);
  assign word_o = {cppr_i, xisr_i};

  always_comb begin
    cppr_o = cppr_i;
    pend_o = pend_i;
    xisr_o = xisr_i;
    if (en_i && (xisr_i != '0)) begin
      cppr_o = pend_i;
      pend_o = '1;
      xisr_o = '0;
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irq_pres_pkg::*;
#(
  parameter int unsigned PRI_W   = 8,
  parameter int unsigned SRC_W   = 24,
  parameter int unsigned IPI_SRC = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           offer_valid,
  output logic                           offer_ready,
  input  logic [SRC_W-1:0]               offer_src,
  input  logic [PRI_W-1:0]               offer_prio,
  input  logic                           acc_valid,
  input  logic                           cppr_wr_valid,
  input  logic [PRI_W-1:0]               cppr_wr_data,
  input  logic                           mfrr_wr_valid,
  input  logic [PRI_W-1:0]               mfrr_wr_data,
  input  logic                           eoi_valid,
  input  logic [PRI_W+SRC_W-1:0]         eoi_word,
  output logic                           offer_done,
  output logic                           offer_taken,
  output logic [REJ_SLOTS-1:0]           rej_valid,
  output logic [REJ_SLOTS*SRC_W-1:0]     rej_src,
  output logic                           resend_req,
  output logic                           eoi_fwd_valid,
  output logic [SRC_W-1:0]               eoi_fwd_src,
  output logic                           xirr_valid,
  output logic [PRI_W+SRC_W-1:0]         xirr_data,
  output logic                           irq_out
);
  localparam int unsigned WORD_W = PRI_W + SRC_W;
  localparam int unsigned NIDX   = NUM_STAGES + 1;
  localparam int unsigned NREJ   = REJ_BASE + REJ_SLOTS;
  localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_SRC);

  // architectural state
  logic [PRI_W-1:0] cppr_q, mfrr_q, pend_q;
  logic [SRC_W-1:0] xisr_q;
  logic             need_q;

  // state as it flows through the ordered stages
  logic [PRI_W-1:0] cppr_s [NIDX];
  logic [PRI_W-1:0] pend_s [NIDX];
  logic [SRC_W-1:0] xisr_s [NIDX];
  logic             need_s [NIDX];
  logic [PRI_W-1:0] mfrr_n;

  logic             rej_raw     [NREJ];
  logic [SRC_W-1:0] rej_src_raw [NREJ];
  logic             rs_eoi, rs_cppr, rs_mfrr;
  logic             taken_c;
  logic [WORD_W-1:0] acc_word;

  assign cppr_s[0] = cppr_q;
  assign pend_s[0] = pend_q;
  assign xisr_s[0] = xisr_q;
  assign need_s[0] = need_q;

  ipr_cppr_stage #(.PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC), .ALWAYS_DOWN(1'b1)) u_eoi (
    .en_i(eoi_valid), .new_cppr_i(eoi_word[WORD_W-1:SRC_W]), .mfrr_i(mfrr_q),
    .cppr_i(cppr_s[STG_EOI]), .pend_i(pend_s[STG_EOI]), .xisr_i(xisr_s[STG_EOI]),
    .need_i(need_s[STG_EOI]),
    .cppr_o(cppr_s[STG_EOI+1]), .pend_o(pend_s[STG_EOI+1]), .xisr_o(xisr_s[STG_EOI+1]),
    .need_o(need_s[STG_EOI+1]),
    .rej_o(rej_raw[STG_EOI]), .rej_src_o(rej_src_raw[STG_EOI]), .resend_o(rs_eoi)
  );

  ipr_cppr_stage #(.PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC), .ALWAYS_DOWN(1'b0)) u_cppr (
    .en_i(cppr_wr_valid), .new_cppr_i(cppr_wr_data), .mfrr_i(mfrr_q),
    .cppr_i(cppr_s[STG_CPPR]), .pend_i(pend_s[STG_CPPR]), .xisr_i(xisr_s[STG_CPPR]),
    .need_i(need_s[STG_CPPR]),
    .cppr_o(cppr_s[STG_CPPR+1]), .pend_o(pend_s[STG_CPPR+1]), .xisr_o(xisr_s[STG_CPPR+1]),
    .need_o(need_s[STG_CPPR+1]),
    .rej_o(rej_raw[STG_CPPR]), .rej_src_o(rej_src_raw[STG_CPPR]), .resend_o(rs_cppr)
  );

  assign cppr_s[STG_MFRR+1] = cppr_s[STG_MFRR];
  ipr_mfrr_stage #(.PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_mfrr (
    .en_i(mfrr_wr_valid), .new_mfrr_i(mfrr_wr_data), .mfrr_i(mfrr_q),
    .cppr_i(cppr_s[STG_MFRR]), .pend_i(pend_s[STG_MFRR]), .xisr_i(xisr_s[STG_MFRR]),
    .need_i(need_s[STG_MFRR]),
    .mfrr_o(mfrr_n), .pend_o(pend_s[STG_MFRR+1]), .xisr_o(xisr_s[STG_MFRR+1]),
    .need_o(need_s[STG_MFRR+1]),
    .rej_o(rej_raw[STG_MFRR]), .rej_src_o(rej_src_raw[STG_MFRR]), .resend_o(rs_mfrr)
  );

  assign cppr_s[STG_OFFER+1] = cppr_s[STG_OFFER];
  ipr_offer_stage #(.PRI_W(PRI_W), .SRC_W(SRC_W)) u_offer (
    .en_i(offer_valid), .src_i(offer_src), .prio_i(offer_prio), .mfrr_i(mfrr_n),
    .cppr_i(cppr_s[STG_OFFER]), .pend_i(pend_s[STG_OFFER]), .xisr_i(xisr_s[STG_OFFER]),
    .need_i(need_s[STG_OFFER]),
    .pend_o(pend_s[STG_OFFER+1]), .xisr_o(xisr_s[STG_OFFER+1]), .need_o(need_s[STG_OFFER+1]),
    .taken_o(taken_c), .rej_o(rej_raw[STG_OFFER]), .rej_src_o(rej_src_raw[STG_OFFER])
  );

  assign need_s[STG_ACCEPT+1] = need_s[STG_ACCEPT];
  ipr_accept_stage #(.PRI_W(PRI_W), .SRC_W(SRC_W)) u_accept (
    .en_i(acc_valid),
    .cppr_i(cppr_s[STG_ACCEPT]), .pend_i(pend_s[STG_ACCEPT]), .xisr_i(xisr_s[STG_ACCEPT]),
    .cppr_o(cppr_s[STG_ACCEPT+1]), .pend_o(pend_s[STG_ACCEPT+1]), .xisr_o(xisr_s[STG_ACCEPT+1]),
    .word_o(acc_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q <= '0;
      mfrr_q <= '1;
      pend_q <= '1;
      xisr_q <= '0;
      need_q <= 1'b0;
    end else begin
      cppr_q <= cppr_s[NUM_STAGES];
      mfrr_q <= mfrr_n;
      pend_q <= pend_s[NUM_STAGES];
      xisr_q <= xisr_s[NUM_STAGES];
      need_q <= need_s[NUM_STAGES];
    end
  end

  // reject slots: filter out the empty source and the IPI pseudo-source
  genvar gs;
  generate
    for (gs = 0; gs < REJ_SLOTS; gs++) begin : g_rej
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rej_valid[gs]                 <= 1'b0;
          rej_src[gs*SRC_W +: SRC_W]    <= '0;
        end else begin
          rej_valid[gs] <= rej_raw[REJ_BASE+gs] &&
                           (rej_src_raw[REJ_BASE+gs] != '0) &&
                           (rej_src_raw[REJ_BASE+gs] != IPI_ID);
          rej_src[gs*SRC_W +: SRC_W] <= rej_src_raw[REJ_BASE+gs];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offer_done    <= 1'b0;
      offer_taken   <= 1'b0;
      resend_req    <= 1'b0;
      eoi_fwd_valid <= 1'b0;
      eoi_fwd_src   <= '0;
      xirr_valid    <= 1'b0;
      xirr_data     <= '0;
    end else begin
      offer_done    <= offer_valid;
      offer_taken   <= taken_c;
      resend_req    <= rs_eoi | rs_cppr | rs_mfrr;
      eoi_fwd_valid <= eoi_valid && (eoi_word[SRC_W-1:0] != IPI_ID);
      eoi_fwd_src   <= eoi_word[SRC_W-1:0];
      xirr_valid    <= acc_valid;
      xirr_data     <= acc_word;
    end
  end

  assign offer_ready = 1'b1;
  assign irq_out     = (xisr_q != '0) && (pend_q < cppr_q);
endmodule

// File: rtl/irq_presenter_checker.sv
module irq_presenter_checker #(
  parameter int unsigned PRI_W   = 8,
  parameter int unsigned SRC_W   = 24,
  parameter int unsigned IPI_SRC = 2,
  parameter int unsigned NSLOT   = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   offer_valid,
  input logic                   acc_valid,
  input logic                   cppr_wr_valid,
  input logic [PRI_W-1:0]       cppr_wr_data,
  input logic                   mfrr_wr_valid,
  input logic                   eoi_valid,
  input logic                   eoi_rej,
  input logic                   offer_done,
  input logic                   offer_taken,
  input logic [NSLOT-1:0]       rej_valid,
  input logic [NSLOT*SRC_W-1:0] rej_src,
  input logic                   resend_req,
  input logic [PRI_W-1:0]       cppr_q,
  input logic [PRI_W-1:0]       pend_q,
  input logic [SRC_W-1:0]       xisr_q,
  input logic                   need_q
);
  localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_SRC);

  logic only_acc, only_cppr;
  assign only_acc  = acc_valid && !offer_valid && !cppr_wr_valid && !mfrr_wr_valid && !eoi_valid;
  assign only_cppr = cppr_wr_valid && !offer_valid && !acc_valid && !mfrr_wr_valid && !eoi_valid;

  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_slot
      // R9: reported sources are never 0 or the IPI number
      p_rej_filtered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid[gi] |-> (rej_src[gi*SRC_W +: SRC_W] != '0) &&
                          (rej_src[gi*SRC_W +: SRC_W] != IPI_ID));
    end
  endgenerate

  // R8: the end-of-interrupt path never displaces a source
  p_eoi_no_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> !eoi_rej);

  // R2: a refused offer leaves the resend flag set
  p_refused_sets_need_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_done && !offer_taken) |-> need_q);

  // R7: a resend request leaves the flag clear unless an offer was refused after it
  p_resend_clears_need_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resend_req && !(offer_done && !offer_taken)) |-> !need_q);

  // R6: an equal threshold write changes no state
  p_equal_cppr_noop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (only_cppr && (cppr_wr_data == cppr_q)) |=>
      ($stable(cppr_q) && $stable(pend_q) && $stable(xisr_q) && $stable(need_q) && !rej_valid[0]));

  // R4: accepting a pending source clears it and moves its priority to the threshold
  p_accept_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (only_acc && (xisr_q != '0)) |=>
      ((xisr_q == '0) && (pend_q == '1) && (cppr_q == $past(pend_q))));
endmodule

bind irq_presenter irq_presenter_checker #(
  .PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC), .NSLOT(irq_pres_pkg::REJ_SLOTS)
) u_checker (
  .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .acc_valid(acc_valid),
  .cppr_wr_valid(cppr_wr_valid), .cppr_wr_data(cppr_wr_data),
  .mfrr_wr_valid(mfrr_wr_valid), .eoi_valid(eoi_valid),
  .eoi_rej(rej_raw[irq_pres_pkg::STG_EOI]),
  .offer_done(offer_done), .offer_taken(offer_taken),
  .rej_valid(rej_valid), .rej_src(rej_src), .resend_req(resend_req),
  .cppr_q(cppr_q), .pend_q(pend_q), .xisr_q(xisr_q), .need_q(need_q)
);

// File: tb/irq_presenter_test.sv
`timescale 1ns/1ps
module irq_presenter_test;
  localparam logic [23:0] IPI = 24'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic offer_valid = 0, acc_valid = 0, cppr_wr_valid = 0, mfrr_wr_valid = 0, eoi_valid = 0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0, cppr_wr_data = '0, mfrr_wr_data = '0;
  logic [31:0] eoi_word = '0;
  logic offer_ready, offer_done, offer_taken, resend_req, eoi_fwd_valid, xirr_valid, irq_out;
  logic [2:0]  rej_valid;
  logic [71:0] rej_src;
  logic [23:0] eoi_fwd_src;
  logic [31:0] xirr_data;

  int n_checks = 0;
  int n_errs = 0;

  // bench model of the architectural state
  logic [7:0]  mc, mm, mp;
  logic [23:0] mx;
  logic        mn;

  always #4 clk = ~clk;

  irq_presenter uut (
    .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_ready(offer_ready),
    .offer_src(offer_src), .offer_prio(offer_prio), .acc_valid(acc_valid),
    .cppr_wr_valid(cppr_wr_valid), .cppr_wr_data(cppr_wr_data),
    .mfrr_wr_valid(mfrr_wr_valid), .mfrr_wr_data(mfrr_wr_data),
    .eoi_valid(eoi_valid), .eoi_word(eoi_word), .offer_done(offer_done),
    .offer_taken(offer_taken), .rej_valid(rej_valid), .rej_src(rej_src),
    .resend_req(resend_req), .eoi_fwd_valid(eoi_fwd_valid), .eoi_fwd_src(eoi_fwd_src),
    .xirr_valid(xirr_valid), .xirr_data(xirr_data), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input string ctx, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s (%s) actual=%0h expected=%0h", tag, ctx, act, exp);
    end
  endtask

  task automatic clear_inputs();
    offer_valid = 0; acc_valid = 0; cppr_wr_valid = 0; mfrr_wr_valid = 0; eoi_valid = 0;
  endtask

  task automatic do_reset();
    clear_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mc = 8'h00; mm = 8'hff; mp = 8'hff; mx = '0; mn = 1'b0;
  endtask

  // apply the driven requests for one clock and compare every output
  task automatic run_cycle(input string ctx);
    logic [7:0]  c, m, p, nv, old;
    logic [23:0] x;
    logic        n, e_rs, e_ot;
    logic [2:0]  e_rv;
    logic [23:0] e_rsrc [3];
    logic [31:0] e_x;
    c = mc; m = mm; p = mp; x = mx; n = mn;
    e_rs = 0; e_ot = 0; e_rv = '0; e_x = '0;
    for (int k = 0; k < 3; k++) e_rsrc[k] = '0;
    if (eoi_valid) begin
      nv = eoi_word[31:24]; c = nv;
      if (m < nv && m <= p) begin p = m; x = IPI; end
      if (n) e_rs = 1; n = 0;
    end
    if (cppr_wr_valid) begin
      nv = cppr_wr_data;
      if (nv > c) begin
        c = nv;
        if (m < nv && m <= p) begin p = m; x = IPI; end
        if (n) e_rs = 1; n = 0;
      end else if (nv < c) begin
        c = nv;
        if (nv <= p) begin
          if (x != 0 && x != IPI) begin e_rv[0] = 1; e_rsrc[0] = x; end
          x = 0; p = 8'hff;
        end
      end
    end
    if (mfrr_wr_valid) begin
      nv = mfrr_wr_data; old = m; m = nv;
      if (nv < c && nv <= p) begin
        if (x != 0 && x != IPI) begin e_rv[1] = 1; e_rsrc[1] = x; end
        p = nv; x = IPI;
      end
      if (nv > old) begin if (n) e_rs = 1; n = 0; end
    end
    if (offer_valid) begin
      if (offer_prio < c && offer_prio < m && offer_prio < p) begin
        e_ot = 1;
        if (x != 0 && x != IPI) begin e_rv[2] = 1; e_rsrc[2] = x; end
        x = offer_src; p = offer_prio;
      end else n = 1;
    end
    if (acc_valid) begin
      e_x = {c, x};
      if (x != 0) begin c = p; p = 8'hff; x = 0; end
    end
    @(posedge clk);
    @(negedge clk);
    chk("R12", ctx, 32'(offer_ready), 32'd1);
    chk("R1", ctx, 32'(offer_done), 32'(offer_valid));
    chk("R1", ctx, 32'(offer_taken), 32'(e_ot));
    chk("R2/R9", ctx, 32'(rej_valid), 32'(e_rv));
    for (int k = 0; k < 3; k++)
      if (e_rv[k]) chk("R2", ctx, 32'(rej_src[k*24 +: 24]), 32'(e_rsrc[k]));
    chk("R5/R7", ctx, 32'(resend_req), 32'(e_rs));
    chk("R8", ctx, 32'(eoi_fwd_valid), 32'(eoi_valid && eoi_word[23:0] != IPI));
    if (eoi_valid && eoi_word[23:0] != IPI) chk("R8", ctx, 32'(eoi_fwd_src), 32'(eoi_word[23:0]));
    chk("R4", ctx, 32'(xirr_valid), 32'(acc_valid));
    if (acc_valid) chk("R4", ctx, xirr_data, e_x);
    chk("R3", ctx, 32'(irq_out), 32'(x != 0 && p < c));
    mc = c; mm = m; mp = p; mx = x; mn = n;
    clear_inputs();
  endtask

  task automatic wr_cppr(input logic [7:0] v, input string ctx);
    cppr_wr_valid = 1; cppr_wr_data = v; run_cycle(ctx);
  endtask
  task automatic wr_mfrr(input logic [7:0] v, input string ctx);
    mfrr_wr_valid = 1; mfrr_wr_data = v; run_cycle(ctx);
  endtask
  task automatic offer(input logic [23:0] s, input logic [7:0] pr, input string ctx);
    offer_valid = 1; offer_src = s; offer_prio = pr; run_cycle(ctx);
  endtask
  task automatic accept(input string ctx);
    acc_valid = 1; run_cycle(ctx);
  endtask
  task automatic eoi(input logic [31:0] w, input string ctx);
    eoi_valid = 1; eoi_word = w; run_cycle(ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [7:0] cps [4] = '{8'd1, 8'd4, 8'd8, 8'd255};
    logic [7:0] mfs [4] = '{8'd2, 8'd4, 8'd6, 8'd255};
    logic [7:0] prs [4] = '{8'd1, 8'd3, 8'd5, 8'd7};
    do_reset();
    @(negedge clk);
    // R10: reset state seen at the ports
    chk("R10", "reset", 32'(irq_out), 32'd0);
    chk("R10", "reset", 32'({offer_done, rej_valid, resend_req, eoi_fwd_valid, xirr_valid}), 32'd0);
    accept("R10 reset accept word");
    chk("R10", "reset accept", xirr_data, 32'h0000_0000);
    wr_mfrr(8'd0, "R10 mfrr was 0xFF so nothing to resend");
    chk("R10", "mfrr lowered", 32'(resend_req), 32'd0);

    // sweep of thresholds, IPI priorities and offer pairs
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++) begin
            do_reset();
            wr_cppr(cps[a], "R7 raise threshold");
            wr_mfrr(mfs[b], "R5 set ipi prio");
            offer(24'h10, prs[i], "R1 first offer");
            offer(24'h20, prs[j], "R1 second offer");
            accept("R4 accept");
            eoi({cps[a], 24'h10}, "R8 eoi");
            wr_mfrr(8'hff, "R5 ipi prio raised");
            offer(24'h30, prs[j], "R2 third offer");
            wr_cppr(8'd0, "R6 lower threshold");
            wr_cppr(8'd0, "R6 equal threshold");
            eoi({8'hff, IPI}, "R8 ipi eoi not forwarded");
            accept("R4 final accept");
          end

    // simultaneous requests in every combination
    for (int mask = 0; mask < 32; mask++) begin
      do_reset();
      wr_cppr(8'd200, "R11 setup");
      offer(24'h44, 8'd100, "R11 setup");
      eoi_valid     = mask[0]; eoi_word     = {8'd150, 24'h44};
      cppr_wr_valid = mask[1]; cppr_wr_data = 8'd90;
      mfrr_wr_valid = mask[2]; mfrr_wr_data = 8'd60;
      offer_valid   = mask[3]; offer_src    = 24'h55; offer_prio = 8'd40;
      acc_valid     = mask[4];
      run_cycle("R11 combined");
      accept("R11 follow-up accept");
    end

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule